// File: doc/BRIEF.md
# Remote Flash Page Programming Sequencer

This block writes one page of a target's flash memory through a word-wide remote memory port, one read or write at a time. After a start strobe it checks that the page address is page-aligned. It polls the flash status word until the controller is idle, then runs a fast page erase. It loads every word of the page from a local buffer, waiting after each word until the controller can take the next one. It then starts the page program, waits for it to finish and clears the control word. Last, it reads the whole page back and compares each word with the buffer.

The local buffer sits outside the block. The sequencer puts a word index on `buf_idx_o` and expects that word on `buf_data_i` in the same cycle. The memory port carries one request at a time. A request stays asserted, with its address, direction and write data held, until the far side answers with a one-cycle acknowledge. How the far side carries those accesses to the target is not part of this block. The default page is 256 bytes, which is 64 words of 32 bits.

Top module: `flash_page_prog`

## Requirements
- R1: A start whose page address has any of its low 8 bits set ends one cycle later with `done_o` and `error_o` high, and no memory request is issued.
- R2: Before erasing, the block reads the status word at 0x4002200C until its bit 0 (busy) reads 0.
- R3: The erase writes 0x00020000 to the control word at 0x40022010 and the page address to the address word at 0x40022014. It then writes 0x00020040 to the control word, polls status bit 0 until it reads 0, and writes 0 to the control word.
- R4: Loading writes 0x00010000 to the control word and the page address to the address word. It then writes buffer word i to the page address plus 4·i, for i ascending from 0 to 63, with `buf_idx_o` equal to i. After each word it polls status bit 1 (write-busy) until that bit reads 0.
- R5: After the last word, the block writes 0x00210000 to the control word, polls status bit 0 until it reads 0, and writes 0 to the control word.
- R6: Each wait makes at most 1000 status reads. If all 1000 reads show the bit set, the run ends with `error_o` high and no further access is made. If the bit clears on the 1000th read, the run goes on.
- R7: After programming, the block reads all 64 words in ascending address order. `mismatch_o` goes high if any word read back differs from its buffer word. A mismatch alone leaves `error_o` low.
- R8: Only one request is outstanding. `mem_req_o` stays high, with address, direction and write data stable, until `mem_ack_i` arrives, and the next request starts after that.
- R9: `done_o` is a one-cycle pulse at the end of a run. `error_o` and `mismatch_o` keep their values until the next accepted start. A start while a run is in progress is ignored.
- R10: After reset, `done_o`, `error_o`, `mismatch_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| page_addr_i | input | 32 | Byte address of the page to program |
| buf_idx_o | output | 6 | Index of the buffer word wanted |
| buf_data_i | input | 32 | Buffer word at `buf_idx_o`, same cycle |
| mem_req_o | output | 1 | Memory request pending |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Target byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | End-of-run pulse |
| error_o | output | 1 | Misaligned page or a wait that timed out |
| mismatch_o | output | 1 | Readback differed from the buffer |

## Verification
The bench models the flash controller. Its busy and write-busy counts and its acknowledge latency are random, and it flags any write that lands while the controller is still busy. A sequencer that skipped or shortened a poll would therefore be caught. The timeout is probed at its edge. A busy bit that clears on the 1000th read must let the run go on. One that never clears must end it with an error after exactly 1000 reads, so an off-by-one counter shows up either way. Other targeted cases check the following:
- A misaligned address must produce no traffic at all.
- A single corrupted readback word must raise the mismatch without the error.
- A second start in the middle of a run must not change the page being written.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

  localparam logic [31:0] FPP_STAT_ADDR = 32'h4002_200C;
  localparam logic [31:0] FPP_CTRL_ADDR = 32'h4002_2010;
  localparam logic [31:0] FPP_AREG_ADDR = 32'h4002_2014;

  localparam int FPP_BUSY_BIT    = 0;
  localparam int FPP_WBUSY_BIT   = 1;
  localparam int FPP_ERSTART_BIT = 6;
  localparam int FPP_FPROG_BIT   = 16;
  localparam int FPP_FERASE_BIT  = 17;
  localparam int FPP_PSTART_BIT  = 21;

  localparam logic [31:0] FPP_CMD_ERSEL = 32'(1) << FPP_FERASE_BIT;
  localparam logic [31:0] FPP_CMD_ERGO  = FPP_CMD_ERSEL | (32'(1) << FPP_ERSTART_BIT);
  localparam logic [31:0] FPP_CMD_PGSEL = 32'(1) << FPP_FPROG_BIT;
  localparam logic [31:0] FPP_CMD_PGGO  = FPP_CMD_PGSEL | (32'(1) << FPP_PSTART_BIT);

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT0, ST_ER_SEL, ST_ER_ADDR, ST_ER_GO, ST_ER_WAIT, ST_ER_CLR,
    ST_PG_SEL, ST_PG_ADDR, ST_PG_WORD, ST_PG_WBSY, ST_PG_GO, ST_PG_WAIT,
    ST_PG_CLR, ST_RD_WORD, ST_DONE
  } fpp_state_e;

endpackage

// File: rtl/fpp_mem_port.sv
module fpp_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);

  logic          req_d;
  logic          hold_en;

  assign hold_en = issue_i;

  always_comb begin
    req_d = req_o;
    if (issue_i)            req_d = 1'b1;
    else if (req_o && ack_i) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (hold_en) begin
      we_o    <= we_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  // R8: a pending request keeps its fields until acknowledged
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)));

  // R8: no new request while one is outstanding
  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> !req_o);

endmodule

// File: rtl/fpp_poll_ctr.sv
module fpp_poll_ctr #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CW'(LIMIT - 1));

  // R6: the number of busy polls seen in one wait stays below the limit
  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIMIT));

endmodule

// File: rtl/fpp_seq.sv
module fpp_seq
  import fpp_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int PAGE_BYTES = 256,
  localparam int BPW       = DW / 8,
  localparam int WORDS     = PAGE_BYTES / BPW,
  localparam int IW        = $clog2(WORDS),
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] page_addr_i,
  output logic [IW-1:0] buf_idx_o,
  input  logic [DW-1:0] buf_data_i,
  output logic          issue_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          req_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          poll_clr_o,
  output logic          poll_inc_o,
  input  logic          poll_last_i,
  output logic          done_o,
  output logic          error_o,
  output logic          mismatch_o
);

  fpp_state_e    state_q, state_d;
  logic          wait_q, wait_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] page_q, page_d;
  logic          err_q, err_d;
  logic          mm_q, mm_d;

  logic          is_acc, is_poll, acc_done, poll_bit, idx_last, misaligned;
  logic [AW-1:0] word_addr;

  assign idx_last   = (idx_q == IW'(WORDS - 1));
  assign word_addr  = page_q + (AW'(idx_q) << $clog2(BPW));
  assign misaligned = |page_addr_i[OFS_W-1:0];
  assign acc_done   = wait_q && req_i && ack_i;
  assign buf_idx_o  = idx_q;

  // access decode per state
  always_comb begin
    is_acc   = 1'b1;
    is_poll  = 1'b0;
    we_o     = 1'b1;
    addr_o   = AW'(FPP_CTRL_ADDR);
    wdata_o  = '0;
    poll_bit = rdata_i[FPP_BUSY_BIT];
    case (state_q)
      ST_WAIT0, ST_ER_WAIT, ST_PG_WAIT, ST_PG_WBSY: begin
        is_poll = 1'b1;
        we_o    = 1'b0;
        addr_o  = AW'(FPP_STAT_ADDR);
        if (state_q == ST_PG_WBSY) poll_bit = rdata_i[FPP_WBUSY_BIT];
      end
      ST_ER_SEL:  wdata_o = DW'(FPP_CMD_ERSEL);
      ST_ER_GO:   wdata_o = DW'(FPP_CMD_ERGO);
      ST_PG_SEL:  wdata_o = DW'(FPP_CMD_PGSEL);
      ST_PG_GO:   wdata_o = DW'(FPP_CMD_PGGO);
      ST_ER_CLR, ST_PG_CLR: wdata_o = '0;
      ST_ER_ADDR, ST_PG_ADDR: begin
        addr_o  = AW'(FPP_AREG_ADDR);
        wdata_o = DW'(page_q);
      end
      ST_PG_WORD: begin
        addr_o  = word_addr;
        wdata_o = buf_data_i;
      end
      ST_RD_WORD: begin
        we_o   = 1'b0;
        addr_o = word_addr;
      end
      default: is_acc = 1'b0;
    endcase
  end

  assign issue_o = is_acc && !wait_q;

  // next state
  always_comb begin
    state_d    = state_q;
    wait_d     = wait_q;
    idx_d      = idx_q;
    page_d     = page_q;
    err_d      = err_q;
    mm_d       = mm_q;
    poll_clr_o = 1'b0;
    poll_inc_o = 1'b0;

    if (issue_o)  wait_d = 1'b1;
    if (acc_done) wait_d = 1'b0;

    case (state_q)
      ST_IDLE: begin
        poll_clr_o = 1'b1;
        if (start_i) begin
          err_d  = misaligned;
          mm_d   = 1'b0;
          idx_d  = '0;
          page_d = page_addr_i;
          state_d = misaligned ? ST_DONE : ST_WAIT0;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: begin
        if (acc_done) begin
          if (is_poll) begin
            if (!poll_bit) begin
              poll_clr_o = 1'b1;
              case (state_q)
                ST_WAIT0:   state_d = ST_ER_SEL;
                ST_ER_WAIT: state_d = ST_ER_CLR;
                ST_PG_WAIT: state_d = ST_PG_CLR;
                default: begin
                  if (idx_last) begin
                    idx_d   = '0;
                    state_d = ST_PG_GO;
                  end else begin
                    idx_d   = idx_q + IW'(1);
                    state_d = ST_PG_WORD;
                  end
                end
              endcase
            end else if (poll_last_i) begin
              poll_clr_o = 1'b1;
              err_d      = 1'b1;
              state_d    = ST_DONE;
            end else begin
              poll_inc_o = 1'b1;
            end
          end else begin
            case (state_q)
              ST_ER_SEL:  state_d = ST_ER_ADDR;
              ST_ER_ADDR: state_d = ST_ER_GO;
              ST_ER_GO:   state_d = ST_ER_WAIT;
              ST_ER_CLR:  state_d = ST_PG_SEL;
              ST_PG_SEL:  state_d = ST_PG_ADDR;
              ST_PG_ADDR: state_d = ST_PG_WORD;
              ST_PG_WORD: state_d = ST_PG_WBSY;
              ST_PG_GO:   state_d = ST_PG_WAIT;
              ST_PG_CLR:  state_d = ST_RD_WORD;
              default: begin
                if (rdata_i != buf_data_i) mm_d = 1'b1;
                if (idx_last) state_d = ST_DONE;
                else          idx_d   = idx_q + IW'(1);
              end
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= 1'b0;
      idx_q   <= '0;
      page_q  <= '0;
      err_q   <= 1'b0;
      mm_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      idx_q   <= idx_d;
      page_q  <= page_d;
      err_q   <= err_d;
      mm_q    <= mm_d;
    end
  end

  assign done_o     = (state_q == ST_DONE);
  assign error_o    = err_q;
  assign mismatch_o = mm_q;

  // R1: a misaligned start finishes at once with an error and no traffic
  assert_misalign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i && misaligned) |=> (done_o && error_o && !req_i));

  // R9: done lasts a single cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: result flags do not move while idle without a start
  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_i) |=> ($stable(error_o) && $stable(mismatch_o)));

endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int PAGE_BYTES = 256,
  parameter int POLL_LIMIT = 1000,
  localparam int IW        = $clog2(PAGE_BYTES / (DW / 8))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] page_addr_i,
  output logic [IW-1:0] buf_idx_o,
  input  logic [DW-1:0] buf_data_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          error_o,
  output logic          mismatch_o
);

  logic          issue, cmd_we, poll_clr, poll_inc, poll_last;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;

  fpp_seq #(.AW(AW), .DW(DW), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .page_addr_i (page_addr_i),
    .buf_idx_o   (buf_idx_o),
    .buf_data_i  (buf_data_i),
    .issue_o     (issue),
    .we_o        (cmd_we),
    .addr_o      (cmd_addr),
    .wdata_o     (cmd_wdata),
    .req_i       (mem_req_o),
    .ack_i       (mem_ack_i),
    .rdata_i     (mem_rdata_i),
    .poll_clr_o  (poll_clr),
    .poll_inc_o  (poll_inc),
    .poll_last_i (poll_last),
    .done_o      (done_o),
    .error_o     (error_o),
    .mismatch_o  (mismatch_o)
  );

  fpp_mem_port #(.AW(AW), .DW(DW)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (issue),
    .we_i    (cmd_we),
    .addr_i  (cmd_addr),
    .wdata_i (cmd_wdata),
    .ack_i   (mem_ack_i),
    .req_o   (mem_req_o),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  fpp_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

endmodule

// File: tb/sim_flash_page_prog.sv
module sim_flash_page_prog;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 64;
  localparam logic [31:0] STAT = 32'h4002_200C;
  localparam logic [31:0] CTRL = 32'h4002_2010;
  localparam logic [31:0] AREG = 32'h4002_2014;

  logic        clk, rst_n, start, req, we, ack, done, err, mm;
  logic [31:0] page_in, addr, wdata, rdata, bdata;
  logic [5:0]  bidx;

  logic [31:0] bufm [0:WORDS-1];
  logic [31:0] flm  [0:WORDS-1];
  logic [31:0] wl_a [0:255];
  logic [31:0] wl_d [0:255];
  logic [31:0] ex_a [0:255];
  logic [31:0] ex_d [0:255];
  logic [31:0] rl_a [0:255];
  int wcnt, rcnt, ecnt, stat_reads, viol, busy_cnt, wbusy_cnt, busy_set, dly, bad_idx;
  logic [31:0] pg_base;
  int checks, errors;
  logic run_done;

  assign bdata = bufm[bidx];

  flash_page_prog u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .page_addr_i(page_in),
    .buf_idx_o(bidx), .buf_data_i(bdata),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_ack_i(ack), .mem_rdata_i(rdata),
    .done_o(done), .error_o(err), .mismatch_o(mm)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // flash controller model
  initial begin
    ack = 1'b0; rdata = '0; dly = 0;
    forever begin
      @(posedge clk); #1;
      if (ack) begin
        ack = 1'b0;
        dly = $urandom_range(0, 2);
      end else if (req) begin
        if (dly > 0) dly--;
        else begin
          ack = 1'b1;
          if (we) begin
            wl_a[wcnt[7:0]] = addr; wl_d[wcnt[7:0]] = wdata; wcnt++;
            if (busy_cnt > 0 || wbusy_cnt > 0) viol++;
            if (addr == CTRL && (wdata[6] || wdata[21])) busy_cnt = busy_set;
            if (addr >= pg_base && addr < pg_base + 256) begin
              flm[(addr - pg_base) >> 2] = wdata;
              wbusy_cnt = $urandom_range(0, 3);
            end
          end else if (addr == STAT) begin
            stat_reads++;
            rdata = {30'b0, wbusy_cnt > 0, busy_cnt > 0};
            if (busy_cnt > 0) busy_cnt--;
            if (wbusy_cnt > 0) wbusy_cnt--;
          end else begin
            rl_a[rcnt[7:0]] = addr; rcnt++;
            rdata = flm[(addr - pg_base) >> 2];
            if (((addr - pg_base) >> 2) == bad_idx) rdata = rdata ^ 32'h0000_0100;
          end
        end
      end
    end
  end

  task automatic build_exp(input logic [31:0] p);
    ecnt = 0;
    ex_a[0] = CTRL; ex_d[0] = 32'h0002_0000;
    ex_a[1] = AREG; ex_d[1] = p;
    ex_a[2] = CTRL; ex_d[2] = 32'h0002_0040;
    ex_a[3] = CTRL; ex_d[3] = 32'h0;
    ex_a[4] = CTRL; ex_d[4] = 32'h0001_0000;
    ex_a[5] = AREG; ex_d[5] = p;
    for (int i = 0; i < WORDS; i++) begin
      ex_a[6+i] = p + 32'(4*i); ex_d[6+i] = bufm[i];
    end
    ex_a[70] = CTRL; ex_d[70] = 32'h0021_0000;
    ex_a[71] = CTRL; ex_d[71] = 32'h0;
    ecnt = 72;
  endtask

  task automatic check_seq(input string tag);
    int bad;
    bad = -1;
    chk(wcnt == ecnt, {tag, " R3 R4 R5 write count"}, 32'(wcnt), 32'(ecnt));
    for (int i = 0; i < ecnt && i < wcnt; i++)
      if (bad < 0 && (wl_a[i] != ex_a[i] || wl_d[i] != ex_d[i])) bad = i;
    chk(bad < 0, {tag, " R3 R4 R5 write order/data"}, (bad < 0) ? 32'h0 : wl_d[bad],
        (bad < 0) ? 32'h0 : ex_d[bad]);
    chk(viol == 0, {tag, " R2 R4 R5 write issued while busy"}, 32'(viol), 32'h0);
    bad = -1;
    for (int i = 0; i < WORDS && i < rcnt; i++)
      if (bad < 0 && rl_a[i] != pg_base + 32'(4*i)) bad = i;
    chk(rcnt == WORDS && bad < 0, {tag, " R7 readback order"}, 32'(rcnt), 32'(WORDS));
  endtask

  task automatic do_run(input logic [31:0] p, input int pre_busy, input int extra_at);
    int n;
    wcnt = 0; rcnt = 0; stat_reads = 0; viol = 0; wbusy_cnt = 0;
    busy_cnt = pre_busy; pg_base = p; run_done = 1'b0;
    for (int i = 0; i < WORDS; i++) flm[i] = 32'hFFFF_FFFF;
    @(negedge clk); page_in = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 30000) begin
      if (n == extra_at && extra_at > 0) begin
        start = 1'b1; page_in = p + 32'd256;
      end else start = 1'b0;
      @(negedge clk); n++;
    end
    start = 1'b0;
    run_done = done;
    chk(done == 1'b1, "R9 run reaches done", 32'(done), 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog R9 act=%h exp=%h", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] p;
    void'($urandom(32'd4242));
    checks = 0; errors = 0; start = 1'b0; page_in = '0; rst_n = 1'b0;
    busy_cnt = 0; wbusy_cnt = 0; busy_set = 3; bad_idx = -1; pg_base = '0;
    wcnt = 0; rcnt = 0; viol = 0; stat_reads = 0;
    for (int i = 0; i < WORDS; i++) bufm[i] = $urandom;
    repeat (3) @(negedge clk);
    chk(!done && !err && !mm && !req, "R10 reset state", {28'b0, done, err, mm, req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 misaligned page
    wcnt = 0; rcnt = 0; stat_reads = 0;
    page_in = 32'h0800_0180; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done && err, "R1 misaligned ends with error", {30'b0, done, err}, 32'h3);
    repeat (5) @(negedge clk);
    chk(wcnt == 0 && stat_reads == 0 && rcnt == 0 && !req, "R1 no access",
        32'(wcnt + stat_reads + rcnt), 32'h0);
    chk(err == 1'b1, "R9 error held while idle", 32'(err), 32'h1);

    // random aligned pages, random busy lengths and data
    for (int r = 0; r < 3; r++) begin
      p = {$urandom} & 32'hFFFF_FF00;
      for (int i = 0; i < WORDS; i++) bufm[i] = $urandom;
      busy_set = $urandom_range(0, 20);
      build_exp(p);
      do_run(p, $urandom_range(0, 6), (r == 1) ? 150 : 0);
      chk(!err && !mm, "R7 clean run flags", {30'b0, err, mm}, 32'h0);
      check_seq("random");
      @(negedge clk);
      chk(!done, "R9 done single cycle", 32'(done), 32'h0);
      if (r == 1) begin
        repeat (20) @(negedge clk);
        chk(!req && wcnt == ecnt, "R9 start during run ignored", 32'(wcnt), 32'(ecnt));
      end
    end

    // directed: all-zero and all-one data at page 0
    for (int i = 0; i < WORDS; i++) bufm[i] = (i % 2) ? 32'hFFFF_FFFF : 32'h0;
    busy_set = 0;
    build_exp(32'h0);
    do_run(32'h0, 0, 0);
    chk(!err && !mm, "R4 alternating data flags", {30'b0, err, mm}, 32'h0);
    check_seq("alt");

    // R7 one corrupted readback word
    bad_idx = 37; busy_set = 2;
    build_exp(32'h0800_0400);
    do_run(32'h0800_0400, 1, 0);
    chk(mm == 1'b1 && err == 1'b0, "R7 mismatch without error", {30'b0, err, mm}, 32'h1);
    repeat (3) @(negedge clk);
    chk(mm == 1'b1, "R9 mismatch held", 32'(mm), 32'h1);
    bad_idx = -1;

    // R6 boundary: busy clears on the 1000th poll
    build_exp(32'h0800_0500);
    do_run(32'h0800_0500, 999, 0);
    chk(!err && !mm, "R6 clear on last poll continues", {30'b0, err, mm}, 32'h0);
    chk(wcnt == ecnt, "R6 run completes after long wait", 32'(wcnt), 32'(ecnt));

    // R6 timeout: busy on all 1000 polls
    do_run(32'h0800_0600, 1000, 0);
    chk(err == 1'b1, "R6 timeout error", 32'(err), 32'h1);
    chk(stat_reads == 1000, "R6 poll count", 32'(stat_reads), 32'd1000);
    repeat (5) @(negedge clk);
    chk(wcnt == 0 && rcnt == 0 && !req, "R6 no access after timeout", 32'(wcnt + rcnt), 32'h0);

    // next start clears flags (R9)
    for (int i = 0; i < WORDS; i++) bufm[i] = $urandom;
    busy_set = 5;
    build_exp(32'h0000_1F00);
    do_run(32'h0000_1F00, 0, 0);
    chk(!err && !mm, "R9 flags cleared by new start", {30'b0, err, mm}, 32'h0);
    check_seq("final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule